// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block links a stereo pair of 24-bit parallel samples to a three-wire serial audio link. It serializes transmit samples onto a data output and deserializes receive samples from a data input. A bit clock and a frame clock pace the link. One of five formats is picked by a 3-bit mode input. Within one mode the transmit and receive directions may use different justification and word lengths. For example, mode 0 sends 24-bit left-justified words while it receives 16-bit right-justified words.

The block runs on a single fast system clock. The bit clock and frame clock come either from an external master or from a companion divider. They are sampled on the system clock, and their edges are detected there. Both phases of the bit clock must last at least one system clock. The frame clock, the serial input and the mode must be synchronous to the system clock, or must have been synchronized before they reach the block. On the parallel side, a valid strobe loads a transmit pair. A one-cycle valid pulse announces each completed received pair.

Top module: `audio_serial_port`

## Requirements
- R1: After reset, `sdout` is 0, `rx_valid` is 0 and both received words are 0.
- R2: Serial words travel MSB first in two's complement. `sdout` changes only in the system cycle after a detected falling bit-clock edge. `sdin` is taken in the system cycle after a detected rising edge.
- R3: The mode codes are 000, 001, 010, 011 and 100 for modes 0 to 4. The codes 101, 110 and 111 behave exactly like 010.
- R4: In every mode except mode 3, the transmitted MSB occupies slot 0 of a half-frame. Slot 0 is the bit period that starts at the falling bit-clock edge where the frame clock changed level.
- R5: In mode 3, slot 0 of each half-frame carries 0 and the MSB occupies slot 1.
- R6: Transmit slots after the 24th word bit carry 0. In a half-frame shorter than the word, only the leading bits are sent.
- R7: The frame clock is high during the left half in all modes except mode 3. In mode 3 the left half is the low half.
- R8: In mode 0 (16 bits), mode 1 (20 bits) and mode 4 (24 bits), the receive word is the last N bits of the half-frame, whatever the half-frame length. Earlier bits are ignored. Shorter words are sign-extended to 24 bits.
- R9: In mode 2 the receive word is slots 0 to 23 of the half-frame. In mode 3 it is slots 1 to 24. All other slots are ignored.
- R10: `rx_valid` pulses for one cycle when a right half-frame ends that followed a fully received left half-frame. At that point `rx_left` and `rx_right` hold that frame. The partial half-frame in progress when the link starts is never reported.
- R11: `tx_valid` loads a transmit pair. The pair is taken up at the start of the next left half-frame. The right half sends the right word that was held at that left edge, even if the pair is reloaded in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Format select |
| bclk | input | 1 | Bit clock |
| lrck | input | 1 | Frame (channel) clock |
| sdin | input | 1 | Serial receive data |
| tx_left | input | 24 | Left transmit sample |
| tx_right | input | 24 | Right transmit sample |
| tx_valid | input | 1 | Loads the transmit pair |
| sdout | output | 1 | Serial transmit data |
| rx_left | output | 24 | Received left sample |
| rx_right | output | 24 | Received right sample |
| rx_valid | output | 1 | One-cycle pulse: received pair complete |

## Verification
The embedded properties watch the following on every cycle:
- `sdout` moves only after a falling bit-clock edge.
- The first transmit slot carries the held MSB in left-justified modes and 0 in mode 3.
- `rx_valid` is a single-cycle pulse that follows a falling edge.

Whole-word content can only be shown by the directed frame scenarios. These cover the per-mode justification, sign extension, ignored filler bits, channel polarity, reserved codes, varying half-frame lengths, start-up suppression and the transmit pair being latched at the left edge.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          bclk,
  input  logic          lrck,
  input  logic          sdin,
  input  logic [DW-1:0] tx_left,
  input  logic [DW-1:0] tx_right,
  input  logic          tx_valid,
  output logic          sdout,
  output logic [DW-1:0] rx_left,
  output logic [DW-1:0] rx_right,
  output logic          rx_valid
);
  localparam logic [CW-1:0] WORD_C = CW'(DW);

  logic          bclk_q, seen, synced, lr_prev, got_left;
  logic [DW:0]   sh;
  logic [DW-1:0] hold_l, hold_r, cur_r, rsh, rword;
  logic [CW-1:0] rcnt;

  wire m_i2s     = (mode == 3'd3);
  wire m_rj      = (mode == 3'd0) || (mode == 3'd1) || (mode == 3'd4);
  wire fall      = bclk_q & ~bclk;
  wire rise      = ~bclk_q & bclk;
  wire edge_f    = fall & seen & (lrck != lr_prev);
  wire left_now  = lrck ^ m_i2s;
  wire left_done = lr_prev ^ m_i2s;
  wire shift_en  = m_rj | (m_i2s ? (rcnt >= 1 && rcnt <= WORD_C) : (rcnt < WORD_C));

  assign sdout = sh[DW];

  always_comb begin
    case (mode)
      3'd0:    rword = {{(DW-16){rsh[15]}}, rsh[15:0]};
      3'd1:    rword = {{(DW-20){rsh[19]}}, rsh[19:0]};
      default: rword = rsh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q   <= 1'b1;
      seen     <= 1'b0;
      synced   <= 1'b0;
      lr_prev  <= 1'b0;
      got_left <= 1'b0;
      sh       <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      cur_r    <= '0;
      rsh      <= '0;
      rcnt     <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      bclk_q   <= bclk;
      rx_valid <= 1'b0;
      if (tx_valid) begin
        hold_l <= tx_left;
        hold_r <= tx_right;
      end
      if (fall) begin
        seen    <= 1'b1;
        lr_prev <= lrck;
        if (edge_f) begin
          synced <= 1'b1;
          rcnt   <= '0;
          rsh    <= '0;
          if (left_now) begin
            sh    <= m_i2s ? {1'b0, hold_l} : {hold_l, 1'b0};
            cur_r <= hold_r;
          end else begin
            sh    <= m_i2s ? {1'b0, cur_r} : {cur_r, 1'b0};
          end
          if (synced) begin
            if (left_done) begin
              rx_left  <= rword;
              got_left <= 1'b1;
            end else begin
              got_left <= 1'b0;
              if (got_left) begin
                rx_right <= rword;
                rx_valid <= 1'b1;
              end
            end
          end
        end else begin
          sh <= {sh[DW-1:0], 1'b0};
        end
      end
      if (rise) begin
        if (shift_en) rsh <= {rsh[DW-2:0], sdin};
        if (rcnt != {CW{1'b1}}) rcnt <= rcnt + 1'b1;
      end
    end
  end

  // R2
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_q && !bclk) |=> $stable(sdout));
  // R4
  lj_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_f && left_now && !m_i2s) |=> sdout == $past(hold_l[DW-1]));
  // R5
  i2s_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_f && m_i2s) |=> !sdout);
  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R10
  valid_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(bclk_q && !bclk));
endmodule

// File: tb/sim_audio_serial_port.sv
`timescale 1ns/1ps
module sim_audio_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic bclk = 1'b1, lrck = 1'b0, sdin = 1'b0, tx_valid = 1'b0;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic sdout, rx_valid;
  logic [23:0] rx_left, rx_right;
  int total = 0, bad = 0, vcnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bclk(bclk), .lrck(lrck), .sdin(sdin),
    .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid),
    .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  always @(negedge clk) if (rst_n && rx_valid) vcnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reset_dut(input logic [2:0] m, input logic lr0);
    @(negedge clk);
    rst_n = 1'b0; mode = m; bclk = 1'b1; lrck = lr0; sdin = 1'b0; tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic slot(input logic lr, input logic din, output logic obs);
    bclk = 1'b0; lrck = lr; sdin = din;
    @(negedge clk); @(negedge clk);
    obs = sdout;
    bclk = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic int fmt_of(input logic [2:0] m);
    case (m)
      3'd0: return 0;
      3'd1: return 1;
      3'd3: return 3;
      3'd4: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic logic [23:0] rx_exp(input int fmt, input logic [23:0] w);
    if (fmt == 0) return {{8{w[15]}}, w[15:0]};
    if (fmt == 1) return {{4{w[19]}}, w[19:0]};
    return w;
  endfunction

  task automatic half(input logic lr, input int n, input int fmt, input logic [23:0] rw,
                      input logic [23:0] tw, input bit chk_on, input string req,
                      input string nm, input bit ld, input logic [23:0] nl, input logic [23:0] nr);
    logic [63:0] obs = '0, exp = '0;
    logic o;
    for (int i = 0; i < n; i++) begin
      logic d, e;
      int w, pos;
      d = ~i[0];
      w = (fmt == 0) ? 16 : (fmt == 1) ? 20 : 24;
      if (fmt == 0 || fmt == 1 || fmt == 4) begin
        if (i >= n - w) d = rw[n-1-i];
      end else if (fmt == 2) begin
        if (i < 24) d = rw[23-i];
      end else begin
        if (i >= 1 && i <= 24) d = rw[24-i];
      end
      pos = i - ((fmt == 3) ? 1 : 0);
      e = (pos >= 0 && pos < 24) ? tw[23-pos] : 1'b0;
      if (ld && i == 2) begin tx_left = nl; tx_right = nr; tx_valid = 1'b1; end
      slot(lr, d, o);
      if (ld && i == 2) tx_valid = 1'b0;
      obs = {obs[62:0], o};
      exp = {exp[62:0], e};
    end
    if (chk_on) chk(obs == exp, req, nm, obs, exp);
  endtask

  task automatic run_frame(input logic [2:0] m, input int n, input logic [23:0] tl,
                           input logic [23:0] tr, input logic [23:0] rl,
                           input logic [23:0] rr, input string req);
    logic lv;
    int fmt, v0;
    logic o;
    lv = (m == 3'd3) ? 1'b0 : 1'b1;
    fmt = fmt_of(m);
    reset_dut(m, ~lv);
    @(negedge clk); tx_left = tl; tx_right = tr; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    half(~lv, 4, fmt, '0, '0, 0, req, "preamble", 0, '0, '0);
    v0 = vcnt;
    half(lv, n, fmt, rl, tl, 1, req, "tx left word", 0, '0, '0);
    half(~lv, n, fmt, rr, tr, 1, req, "tx right word", 0, '0, '0);
    bclk = 1'b0; lrck = lv; sdin = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(vcnt == v0 + 1, "R10", "rx_valid pulse count", 64'(vcnt - v0), 64'd1);
    chk(rx_left == rx_exp(fmt, rl), req, "rx left word", 64'(rx_left), 64'(rx_exp(fmt, rl)));
    chk(rx_right == rx_exp(fmt, rr), req, "rx right word", 64'(rx_right), 64'(rx_exp(fmt, rr)));
    slot(lv, 1'b0, o);
  endtask

  task automatic t_reset;
    reset_dut(3'd2, 1'b0);
    chk(sdout == 1'b0, "R1", "sdout after reset", 64'(sdout), 64'd0);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", 64'(rx_valid), 64'd0);
    chk(rx_left == '0 && rx_right == '0, "R1", "rx words after reset",
        {16'd0, rx_left, rx_right}, 64'd0);
  endtask

  task automatic t_startup;
    int v0;
    reset_dut(3'd2, 1'b1);
    v0 = vcnt;
    half(1'b1, 5, 2, 24'h123456, '0, 0, "R10", "", 0, '0, '0);
    half(1'b0, 24, 2, 24'h654321, '0, 0, "R10", "", 0, '0, '0);
    half(1'b1, 24, 2, 24'h111111, '0, 0, "R10", "", 0, '0, '0);
    chk(vcnt == v0, "R10", "no pulse for partial start", 64'(vcnt - v0), 64'd0);
  endtask

  task automatic t_reload;
    int v0;
    logic o;
    reset_dut(3'd2, 1'b0);
    @(negedge clk); tx_left = 24'hA5A5A5; tx_right = 24'h3C3C3C; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    half(1'b0, 4, 2, '0, '0, 0, "R11", "", 0, '0, '0);
    v0 = vcnt;
    half(1'b1, 32, 2, '0, 24'hA5A5A5, 1, "R11", "left word before reload", 1, 24'h0F0F0F, 24'hF0F0F0);
    half(1'b0, 32, 2, '0, 24'h3C3C3C, 1, "R11", "right word held at left edge", 0, '0, '0);
    half(1'b1, 32, 2, '0, 24'h0F0F0F, 1, "R11", "reloaded left word", 0, '0, '0);
    half(1'b0, 32, 2, '0, 24'hF0F0F0, 1, "R11", "reloaded right word", 0, '0, '0);
    slot(1'b1, 1'b0, o);
    chk(vcnt == v0 + 2, "R10", "pulses over two frames", 64'(vcnt - v0), 64'd2);
  endtask

  initial begin
    t_reset();
    run_frame(3'd0, 16, 24'hC0FFEE, 24'h5A5A5A, 24'h00F00D, 24'h00BEEF, "R6");
    run_frame(3'd0, 32, 24'h800001, 24'h7FFFFE, 24'h001234, 24'h00ABCD, "R8");
    run_frame(3'd1, 20, 24'h13579B, 24'h2468AC, 24'h0FEDCB, 24'h054321, "R8");
    run_frame(3'd1, 32, 24'hFEDCBA, 24'h012345, 24'h087654, 24'h012345, "R8");
    run_frame(3'd2, 24, 24'h9ABCDE, 24'h123456, 24'hDEADBE, 24'h0CAFE0, "R4");
    run_frame(3'd2, 32, 24'h876543, 24'h456789, 24'hA1B2C3, 24'h3C2B1A, "R9");
    run_frame(3'd3, 32, 24'hF00F0F, 24'h0FF0F0, 24'h9E3779, 24'h7F4A7C, "R5");
    run_frame(3'd3, 26, 24'h8000FF, 24'h400001, 24'h800000, 24'h7FFFFF, "R7");
    run_frame(3'd4, 24, 24'h111111, 24'hEEEEEE, 24'hF12345, 24'h0ABCDE, "R8");
    run_frame(3'd4, 32, 24'h808080, 24'h7F7F7F, 24'h800000, 24'h7FFFFF, "R2");
    run_frame(3'd7, 32, 24'h3A3A3A, 24'hC5C5C5, 24'h5DEECE, 24'h66D0E1, "R3");
    run_frame(3'd5, 28, 24'h010203, 24'hFCFDFE, 24'hB00B00, 24'h0DDBA1, "R3");
    t_startup();
    t_reload();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule